// File: doc/BRIEF.md
# Strap-Selected Management Address-Mode Responder

This block is the device-side front end of a two-wire management register bus for a chip that holds many internal register banks. It receives frames that an upstream deserializer has already decoded (target bus address, register number, direction and a 16-bit data word) and turns them into requests on a simple request/acknowledge port towards the internal banks. Bit-level serial framing and the contents of the banks live elsewhere.

A four-bit strap, latched while reset is held, selects the addressing scheme. The device address is the strap shifted left by one, so only even addresses can be chosen. A zero strap makes the block the only device on the bus: it answers all 32 bus addresses and each address selects one internal bank directly. A non-zero strap lets several devices share the bus. The block then answers only its own address and shows a command register and a data register there. A bus master uses these two registers to reach the internal banks indirectly, polling a busy flag until each access completes.

Top module: `smi_addr_responder`

## Requirements
- R1: After reset, `bk_req` and `rsp_valid` are low, and in indirect mode both the command register and the data register read as 0x0000.
- R2: The device address is `{strap_addr, 1'b0}`, sampled only while `rst` is high. A strap change after reset has no effect until the next reset.
- R3: With a zero strap, a frame at any bus address P and register Rg raises `bk_req` in the following cycle, with `bk_dev`=P, `bk_reg`=Rg, and the frame's direction and data on `bk_write`/`bk_wdata`.
- R4: In direct mode, a read is answered with `rsp_valid` high for one cycle, the cycle after `bk_ack`, with `rsp_rdata` equal to the `bk_rdata` value sampled with the ack. A write gives no response.
- R5: `bk_req` and its fields stay constant until `bk_ack`. In direct mode, a frame that arrives while a request is pending is dropped.
- R6: With a non-zero strap, frames whose bus address differs from the device address cause no bank request and no response.
- R7: The data register sits at offset 1. A write while not busy loads it, and a read returns its value one cycle after the frame.
- R8: The command register sits at offset 0, with the layout bit 15 busy, bit 12 clause-22 marker, bits 11:10 opcode (01 write, 10 read), bits 9:5 internal device, bits 4:0 internal register. A command write with a valid opcode while idle raises `bk_req` in the next cycle with these fields. A write command carries the current data register value.
- R9: When an indirect read is acknowledged, the data register takes `bk_rdata`.
- R10: Busy is set from the cycle after an accepted command until `bk_ack`. A command register read returns busy in bit 15, bits 14:13 as zero, and bits 12:0 of the last accepted command.
- R11: While busy, command writes and data register writes are dropped. The access in flight and its fields are unchanged, and `bk_req` falls in the cycle after `bk_ack`.
- R12: At the device address, offsets other than 0 and 1 ignore writes and read as 0xFFFF.
- R13: A command with opcode 00 or 11 is ignored: no request is raised, busy stays clear, and the stored command is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the strap is latched while it is high |
| strap_addr | input | 4 | Upper four bits of the device address |
| frm_valid | input | 1 | One-cycle pulse marking a decoded bus frame |
| frm_phy | input | 5 | Bus address of the frame |
| frm_reg | input | 5 | Register number of the frame |
| frm_write | input | 1 | 1 = write frame, 0 = read frame |
| frm_wdata | input | 16 | Write data of the frame |
| rsp_valid | output | 1 | One-cycle pulse: read data is available |
| rsp_rdata | output | 16 | Read data returned to the bus |
| bk_req | output | 1 | Internal bank access request, held until ack |
| bk_dev | output | 5 | Internal bank (device) index |
| bk_reg | output | 5 | Register within the bank |
| bk_write | output | 1 | 1 = write access |
| bk_wdata | output | 16 | Data for a write access |
| bk_ack | input | 1 | Bank acknowledges the pending request |
| bk_rdata | input | 16 | Bank read data, valid with `bk_ack` |

## Verification
A mode latched from the wrong strap shows at once: the first frame to a foreign address either raises `bk_req` in the next cycle or goes unanswered. A busy flag that sticks or clears early is seen at the next poll of the command register, and also as a second command that is accepted when it should be dropped, which changes `bk_dev` one cycle later. A data register that misses the acknowledged read data, or that is overwritten during an access, returns the wrong word on the first data read after the ack.

// File: rtl/smi_resp_pkg.sv
`timescale 1ns/1ps
package smi_resp_pkg;
    localparam int PHY_W   = 5;
    localparam int REG_W   = 5;
    localparam int DATA_W  = 16;
    localparam int STRAP_W = PHY_W - 1;

    // Register offsets visible at the strapped address (indirect mode).
    localparam logic [REG_W-1:0]  OFS_CMD     = REG_W'(0);
    localparam logic [REG_W-1:0]  OFS_DATA    = REG_W'(1);
    localparam logic [DATA_W-1:0] RD_UNMAPPED = {DATA_W{1'b1}};

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_RSVD  = 2'b11
    } smi_op_e;

    // Stored part of the command word (bits 12:0).
    typedef struct packed {
        logic             c22;
        smi_op_e          op;
        logic [PHY_W-1:0] dev;
        logic [REG_W-1:0] rg;
    } cmd_body_t;

    localparam int CMD_BODY_W = $bits(cmd_body_t);
    localparam int CMD_PAD_W  = DATA_W - 1 - CMD_BODY_W;

    typedef struct packed {
        logic [PHY_W-1:0]  dev;
        logic [REG_W-1:0]  rg;
        logic              wr;
        logic [DATA_W-1:0] wdata;
    } bank_req_t;

    function automatic logic op_is_valid(smi_op_e op);
        return (op == OP_WRITE) || (op == OP_READ);
    endfunction

    function automatic logic [DATA_W-1:0] cmd_word(logic busy, cmd_body_t body);
        return {busy, {CMD_PAD_W{1'b0}}, body};
    endfunction
endpackage

// File: rtl/smi_frame_decode.sv
`timescale 1ns/1ps
module smi_frame_decode
    import smi_resp_pkg::*;
(
    input  logic             direct,
    input  logic [PHY_W-1:0] own_addr,
    input  logic             frm_valid,
    input  logic [PHY_W-1:0] frm_phy,
    input  logic             port_busy,
    output logic             direct_start,
    output logic             ind_hit
);
    // Direct mode: every address maps to a bank; drop frames while busy.
    assign direct_start = direct & frm_valid & ~port_busy;
    // Indirect mode: only the strapped address is ours.
    assign ind_hit      = ~direct & frm_valid & (frm_phy == own_addr);
endmodule

// File: rtl/smi_bank_port.sv
`timescale 1ns/1ps
module smi_bank_port
    import smi_resp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  bank_req_t         start_req,
    output logic              busy,
    output logic              done,
    output logic [PHY_W-1:0]  bk_dev,
    output logic [REG_W-1:0]  bk_reg,
    output logic              bk_write,
    output logic [DATA_W-1:0] bk_wdata,
    input  logic              bk_ack
);
    bank_req_t req_q;
    logic      pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            req_q  <= '0;
        end else if (pend_q) begin
            if (bk_ack) pend_q <= 1'b0;
        end else if (start) begin
            pend_q <= 1'b1;
            req_q  <= start_req;
        end
    end

    assign busy     = pend_q;
    assign done     = pend_q & bk_ack;
    assign bk_dev   = req_q.dev;
    assign bk_reg   = req_q.rg;
    assign bk_write = req_q.wr;
    assign bk_wdata = req_q.wdata;
endmodule

// File: rtl/smi_indirect_regs.sv
`timescale 1ns/1ps
module smi_indirect_regs
    import smi_resp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic [REG_W-1:0]  frm_reg,
    input  logic              frm_write,
    input  logic [DATA_W-1:0] frm_wdata,
    input  logic              port_busy,
    input  logic              port_done,
    input  logic [DATA_W-1:0] bk_rdata,
    output logic              start,
    output bank_req_t         start_req,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    cmd_body_t         cmd_q;
    cmd_body_t         cmd_in;
    logic [DATA_W-1:0] data_q;
    logic              wr_cmd, wr_data;
    logic [DATA_W-1:0] rd_mux;

    assign cmd_in  = cmd_body_t'(frm_wdata[CMD_BODY_W-1:0]);
    assign wr_cmd  = hit & frm_write & (frm_reg == OFS_CMD)  & ~port_busy;
    assign wr_data = hit & frm_write & (frm_reg == OFS_DATA) & ~port_busy;
    assign start   = wr_cmd & op_is_valid(cmd_in.op);

    always_comb begin
        start_req.dev   = cmd_in.dev;
        start_req.rg    = cmd_in.rg;
        start_req.wr    = (cmd_in.op == OP_WRITE);
        start_req.wdata = data_q;
    end

    always_comb begin
        if (frm_reg == OFS_CMD)       rd_mux = cmd_word(port_busy, cmd_q);
        else if (frm_reg == OFS_DATA) rd_mux = data_q;
        else                          rd_mux = RD_UNMAPPED;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q     <= '0;
            data_q    <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            if (start) cmd_q <= cmd_in;
            if (wr_data)
                data_q <= frm_wdata;
            else if (port_done && cmd_q.op == OP_READ)
                data_q <= bk_rdata;
            rsp_valid <= hit & ~frm_write;
            rsp_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/smi_addr_responder.sv
`timescale 1ns/1ps
module smi_addr_responder
    import smi_resp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [STRAP_W-1:0] strap_addr,
    input  logic               frm_valid,
    input  logic [PHY_W-1:0]   frm_phy,
    input  logic [REG_W-1:0]   frm_reg,
    input  logic               frm_write,
    input  logic [DATA_W-1:0]  frm_wdata,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               bk_req,
    output logic [PHY_W-1:0]   bk_dev,
    output logic [REG_W-1:0]   bk_reg,
    output logic               bk_write,
    output logic [DATA_W-1:0]  bk_wdata,
    input  logic               bk_ack,
    input  logic [DATA_W-1:0]  bk_rdata
);
    logic [STRAP_W-1:0] strap_q;
    logic               direct_mode;
    logic [PHY_W-1:0]   dev_addr;

    logic              port_busy, port_done;
    logic              dir_start, ind_hit, ind_start, any_start;
    bank_req_t         dir_req, ind_req, sel_req;
    logic              ind_rsp_v;
    logic [DATA_W-1:0] ind_rsp_d;
    logic              dir_rsp_v;
    logic [DATA_W-1:0] dir_rsp_d;

    // Strap is sampled only while reset is held.
    always_ff @(posedge clk) begin
        if (rst) strap_q <= strap_addr;
    end

    assign direct_mode = (strap_q == '0);
    assign dev_addr    = {strap_q, 1'b0};

    smi_frame_decode u_dec (
        .direct       (direct_mode),
        .own_addr     (dev_addr),
        .frm_valid    (frm_valid),
        .frm_phy      (frm_phy),
        .port_busy    (port_busy),
        .direct_start (dir_start),
        .ind_hit      (ind_hit)
    );

    smi_indirect_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .hit       (ind_hit),
        .frm_reg   (frm_reg),
        .frm_write (frm_write),
        .frm_wdata (frm_wdata),
        .port_busy (port_busy),
        .port_done (port_done),
        .bk_rdata  (bk_rdata),
        .start     (ind_start),
        .start_req (ind_req),
        .rsp_valid (ind_rsp_v),
        .rsp_rdata (ind_rsp_d)
    );

    always_comb begin
        dir_req.dev   = frm_phy;
        dir_req.rg    = frm_reg;
        dir_req.wr    = frm_write;
        dir_req.wdata = frm_wdata;
    end

    assign any_start = dir_start | ind_start;
    assign sel_req   = direct_mode ? dir_req : ind_req;

    smi_bank_port u_port (
        .clk       (clk),
        .rst       (rst),
        .start     (any_start),
        .start_req (sel_req),
        .busy      (port_busy),
        .done      (port_done),
        .bk_dev    (bk_dev),
        .bk_reg    (bk_reg),
        .bk_write  (bk_write),
        .bk_wdata  (bk_wdata),
        .bk_ack    (bk_ack)
    );

    assign bk_req = port_busy;

    // Direct-mode read data is returned the cycle after the ack.
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_rsp_v <= 1'b0;
            dir_rsp_d <= '0;
        end else begin
            dir_rsp_v <= direct_mode & port_done & ~bk_write;
            dir_rsp_d <= bk_rdata;
        end
    end

    assign rsp_valid = dir_rsp_v | ind_rsp_v;
    assign rsp_rdata = dir_rsp_v ? dir_rsp_d : ind_rsp_d;
endmodule

// File: rtl/smi_addr_responder_chk.sv
`timescale 1ns/1ps
module smi_addr_responder_chk
    import smi_resp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              direct,
    input logic [PHY_W-1:0]  dev_addr,
    input logic              frm_valid,
    input logic [PHY_W-1:0]  frm_phy,
    input logic [REG_W-1:0]  frm_reg,
    input logic              frm_write,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              bk_req,
    input logic [PHY_W-1:0]  bk_dev,
    input logic [REG_W-1:0]  bk_reg,
    input logic              bk_write,
    input logic [DATA_W-1:0] bk_wdata,
    input logic              bk_ack,
    input logic [DATA_W-1:0] bk_rdata
);
    a_r3_direct_issue: assert property (@(posedge clk) disable iff (rst)
        (direct && frm_valid && !bk_req) |=>
        (bk_req && bk_dev == $past(frm_phy) && bk_reg == $past(frm_reg)
         && bk_write == $past(frm_write)));

    a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        (bk_req && !bk_ack) |=>
        (bk_req && $stable(bk_dev) && $stable(bk_reg)
         && $stable(bk_write) && $stable(bk_wdata)));

    a_r4_direct_read_resp: assert property (@(posedge clk) disable iff (rst)
        (direct && bk_req && bk_ack && !bk_write) |=>
        (rsp_valid && rsp_rdata == $past(bk_rdata)));

    a_r4_direct_write_silent: assert property (@(posedge clk) disable iff (rst)
        (direct && bk_req && bk_ack && bk_write) |=> !rsp_valid);

    a_r6_foreign_quiet: assert property (@(posedge clk) disable iff (rst)
        (!direct && frm_valid && frm_phy != dev_addr && !bk_req) |=>
        (!bk_req && !rsp_valid));

    a_r11_release_on_ack: assert property (@(posedge clk) disable iff (rst)
        (bk_req && bk_ack) |=> !bk_req);
endmodule

bind smi_addr_responder smi_addr_responder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .direct    (direct_mode),
    .dev_addr  (dev_addr),
    .frm_valid (frm_valid),
    .frm_phy   (frm_phy),
    .frm_reg   (frm_reg),
    .frm_write (frm_write),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .bk_req    (bk_req),
    .bk_dev    (bk_dev),
    .bk_reg    (bk_reg),
    .bk_write  (bk_write),
    .bk_wdata  (bk_wdata),
    .bk_ack    (bk_ack),
    .bk_rdata  (bk_rdata)
);

// File: tb/smi_addr_responder_test.sv
`timescale 1ns/1ps
module smi_addr_responder_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  strap_addr;
    logic        frm_valid;
    logic [4:0]  frm_phy;
    logic [4:0]  frm_reg;
    logic        frm_write;
    logic [15:0] frm_wdata;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        bk_req;
    logic [4:0]  bk_dev;
    logic [4:0]  bk_reg;
    logic        bk_write;
    logic [15:0] bk_wdata;
    logic        bk_ack;
    logic [15:0] bk_rdata;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #10 clk = ~clk;

    smi_addr_responder uut (
        .clk(clk), .rst(rst), .strap_addr(strap_addr),
        .frm_valid(frm_valid), .frm_phy(frm_phy), .frm_reg(frm_reg),
        .frm_write(frm_write), .frm_wdata(frm_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .bk_req(bk_req), .bk_dev(bk_dev), .bk_reg(bk_reg),
        .bk_write(bk_write), .bk_wdata(bk_wdata),
        .bk_ack(bk_ack), .bk_rdata(bk_rdata)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            bad = bad + 1;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total + 1, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the capture edge.
    task automatic send(input logic [4:0] phy, input logic [4:0] rg, input logic wr, input logic [15:0] wd);
        frm_valid = 1'b1; frm_phy = phy; frm_reg = rg; frm_write = wr; frm_wdata = wd;
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    task automatic ack(input logic [15:0] d);
        bk_ack = 1'b1; bk_rdata = d;
        @(negedge clk);
        bk_ack = 1'b0;
    endtask

    task automatic do_reset(input logic [3:0] s);
        rst = 1'b1; strap_addr = s;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic rd_check(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] exp, input string tag);
        send(phy, rg, 1'b0, 16'h0);
        check(rsp_valid === 1'b1, tag, {31'd0, rsp_valid}, 32'd1);
        check(rsp_rdata === exp, tag, {16'd0, rsp_rdata}, {16'd0, exp});
    endtask

    typedef struct packed {
        logic [4:0]  phy;
        logic [4:0]  rg;
        logic        wr;
        logic [15:0] wd;
        logic [15:0] rd;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{5'd0,  5'd0,  1'b0, 16'h0000, 16'h1234},
        '{5'd31, 5'd31, 1'b1, 16'hA5A5, 16'h0000},
        '{5'd6,  5'd3,  1'b0, 16'h0000, 16'h0F0F},
        '{5'd17, 5'd12, 1'b1, 16'h0001, 16'h0000},
        '{5'd2,  5'd0,  1'b0, 16'h0000, 16'hFFFF},
        '{5'd30, 5'd1,  1'b1, 16'h8000, 16'h0000}
    };

    initial begin
        frm_valid = 0; frm_phy = 0; frm_reg = 0; frm_write = 0; frm_wdata = 0;
        bk_ack = 0; bk_rdata = 0; rst = 1; strap_addr = 0;
        @(negedge clk);

        // ---------------- direct mode (strap 0) ----------------
        do_reset(4'd0);
        check(bk_req === 1'b0, "R1 req", {31'd0, bk_req}, 0);
        check(rsp_valid === 1'b0, "R1 rsp", {31'd0, rsp_valid}, 0);

        for (int i = 0; i < 6; i++) begin
            vec_t v = VECS[i];
            send(v.phy, v.rg, v.wr, v.wd);
            check(bk_req === 1'b1, "R3 req", {31'd0, bk_req}, 1);
            check(bk_dev === v.phy && bk_reg === v.rg, "R3 addr",
                  {22'd0, bk_dev, bk_reg}, {22'd0, v.phy, v.rg});
            check(bk_write === v.wr, "R3 dir", {31'd0, bk_write}, {31'd0, v.wr});
            if (v.wr) check(bk_wdata === v.wd, "R3 wdata", {16'd0, bk_wdata}, {16'd0, v.wd});
            ack(v.rd);
            check(rsp_valid === !v.wr, "R4 rsp_valid", {31'd0, rsp_valid}, {31'd0, !v.wr});
            if (!v.wr) check(rsp_rdata === v.rd, "R4 rdata", {16'd0, rsp_rdata}, {16'd0, v.rd});
            check(bk_req === 1'b0, "R11 release", {31'd0, bk_req}, 0);
        end

        // R5: second frame while pending is dropped
        send(5'd9, 5'd4, 1'b0, 16'h0);
        send(5'd20, 5'd7, 1'b1, 16'h5555);
        check(bk_dev === 5'd9 && bk_reg === 5'd4 && bk_write === 1'b0, "R5 hold",
              {22'd0, bk_dev, bk_reg}, {22'd0, 5'd9, 5'd4});
        ack(16'h7777);
        @(negedge clk);
        check(bk_req === 1'b0, "R5 dropped", {31'd0, bk_req}, 0);

        // ---------------- indirect mode (strap 3 -> address 6) ----------------
        do_reset(4'd3);
        check(bk_req === 1'b0, "R1 req ind", {31'd0, bk_req}, 0);
        rd_check(5'd6, 5'd0, 16'h0000, "R1 cmd");
        rd_check(5'd6, 5'd1, 16'h0000, "R1 data");

        send(5'd6, 5'd1, 1'b1, 16'hBEEF);
        rd_check(5'd6, 5'd1, 16'hBEEF, "R7 data");

        // R6: foreign address
        send(5'd7, 5'd1, 1'b1, 16'h1111);
        check(bk_req === 1'b0, "R6 wr", {31'd0, bk_req}, 0);
        send(5'd0, 5'd0, 1'b1, 16'h1469);
        check(bk_req === 1'b0, "R6 cmd", {31'd0, bk_req}, 0);
        send(5'd7, 5'd1, 1'b0, 16'h0);
        check(rsp_valid === 1'b0, "R6 rd", {31'd0, rsp_valid}, 0);
        rd_check(5'd6, 5'd1, 16'hBEEF, "R6 data kept");

        // R8: write command c22|op01|dev3|reg9 = 0x1469
        send(5'd6, 5'd0, 1'b1, 16'h1469);
        check(bk_req === 1'b1 && bk_write === 1'b1, "R8 req", {30'd0, bk_req, bk_write}, 3);
        check(bk_dev === 5'd3 && bk_reg === 5'd9, "R8 addr", {22'd0, bk_dev, bk_reg}, {22'd0, 5'd3, 5'd9});
        check(bk_wdata === 16'hBEEF, "R8 wdata", {16'd0, bk_wdata}, 32'hBEEF);
        rd_check(5'd6, 5'd0, 16'h9469, "R10 busy set");

        // R11: command and data writes while busy dropped
        send(5'd6, 5'd0, 1'b1, 16'h18A2);
        check(bk_dev === 5'd3 && bk_write === 1'b1, "R11 cmd drop", {26'd0, bk_dev, bk_write}, {26'd0, 5'd3, 1'b1});
        send(5'd6, 5'd1, 1'b1, 16'h2222);
        rd_check(5'd6, 5'd0, 16'h9469, "R11 cmd kept");
        rd_check(5'd6, 5'd1, 16'hBEEF, "R11 data kept");
        ack(16'h0000);
        check(bk_req === 1'b0, "R11 release", {31'd0, bk_req}, 0);
        rd_check(5'd6, 5'd0, 16'h1469, "R10 busy clear");

        // R9: indirect read c22|op10|dev5|reg2 = 0x18A2
        send(5'd6, 5'd0, 1'b1, 16'h18A2);
        check(bk_req === 1'b1 && bk_write === 1'b0, "R8 rd req", {30'd0, bk_req, bk_write}, 2);
        check(bk_dev === 5'd5 && bk_reg === 5'd2, "R8 rd addr", {22'd0, bk_dev, bk_reg}, {22'd0, 5'd5, 5'd2});
        ack(16'hCAFE);
        rd_check(5'd6, 5'd1, 16'hCAFE, "R9 data");
        rd_check(5'd6, 5'd0, 16'h18A2, "R10 cmd idle");

        // R12: unmapped offsets
        rd_check(5'd6, 5'd2, 16'hFFFF, "R12 read");
        rd_check(5'd6, 5'd31, 16'hFFFF, "R12 read top");
        send(5'd6, 5'd3, 1'b1, 16'h3333);
        check(bk_req === 1'b0, "R12 no req", {31'd0, bk_req}, 0);
        rd_check(5'd6, 5'd1, 16'hCAFE, "R12 data kept");
        rd_check(5'd6, 5'd0, 16'h18A2, "R12 cmd kept");

        // R13: invalid opcodes 11 and 00
        send(5'd6, 5'd0, 1'b1, 16'h1C41);
        check(bk_req === 1'b0, "R13 op11", {31'd0, bk_req}, 0);
        send(5'd6, 5'd0, 1'b1, 16'h1041);
        check(bk_req === 1'b0, "R13 op00", {31'd0, bk_req}, 0);
        rd_check(5'd6, 5'd0, 16'h18A2, "R13 cmd kept");

        // R2: strap change after reset has no effect
        strap_addr = 4'd5;
        rd_check(5'd6, 5'd1, 16'hCAFE, "R2 old addr");
        send(5'd10, 5'd1, 1'b0, 16'h0);
        check(rsp_valid === 1'b0, "R2 new addr", {31'd0, rsp_valid}, 0);

        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule